// File: doc/BRIEF.md
# Limit Watchdog with Sticky Interrupt Status

This block watches a set of stored monitor readings. Each reading has an upper limit and a lower limit of its own. When a reading leaves its allowed range, a sticky status bit is set for that channel. A status bit stays set until the host reads the status byte that holds it, which clears that byte.

Each channel works in one of two modes. In window mode the channel alarms whenever the reading is outside the range set by its two limits. In hysteresis mode the lower limit is the release point: the alarm starts above the upper limit and ends only when the reading falls to or below the lower limit.

Two separate mask vectors decide which status bits reach the system-management interrupt and which reach the general interrupt. The first is an active-low open-drain output with its own enable. The second has selectable polarity. The block also takes a chassis-intrusion line: it synchronises the line and records it as one more status bit. On request it drives the line low for a timed minimum interval, counted in ticks of a slow timebase, so that the external latch can be cleared.

Top module: `limit_watchdog`

## Requirements
- R1: During and after synchronous reset, all status bits are 0, `smi_n` is 1, `case_drive` is 0 and every channel alarm is clear. One cycle after reset, `irq` sits at its inactive level for the selected polarity.
- R2: In window mode (`mode_win` bit = 1), a channel alarms whenever its unsigned reading is greater than its upper limit or less than its lower limit.
- R3: In hysteresis mode (`mode_win` bit = 0), the alarm sets when the reading is greater than the upper limit. It clears when the reading is less than or equal to the lower limit, and holds its value for readings in between.
- R4: Status bit i belongs to status byte i/8, and to the bit i%8 inside that byte. A set bit stays set until a `rd_clr` pulse on its byte. If a set and a clear land in the same cycle, the set wins.
- R5: While `run` is 0, channel alarms hold their state and set no status bits.
- R6: The case-open input passes through SYNC_STAGES flops. While it is high, it sets status bit NUM_CH, whatever the value of `run`.
- R7: `smi_n` is 0 only when `smi_en` is 1 and some status bit whose `smi_mask` bit is 0 is set. A mask bit of 1 blocks its status bit.
- R8: `irq` is active when some status bit whose `irq_mask` bit is 0 is set. The active level is 1 when `irq_pol` is 1 and 0 when `irq_pol` is 0.
- R9: Mask bits do not stop status bits from setting.
- R10: A rising edge on `case_clr_req` asserts `case_drive`. The drive stays asserted until PULSE_TICKS+1 `tick` pulses have been counted, so it lasts at least PULSE_TICKS full tick periods. Request edges that arrive while the drive is active are ignored. Holding the request high does not restart the pulse.
- R11: Latency: a channel's status bit reflects its inputs two clock edges after they are applied. `smi_n` and `irq` follow the status one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Enables the channel comparators |
| mode_win | input | NUM_CH | Per-channel mode: 1 window, 0 hysteresis |
| mon_val | input | NUM_CH*DW | Packed monitor readings, channel 0 in the low bits |
| lim_hi | input | NUM_CH*DW | Packed upper limits |
| lim_lo | input | NUM_CH*DW | Packed lower limits or release points |
| smi_mask | input | NUM_CH+1 | Per-status-bit block for the system-management interrupt |
| irq_mask | input | NUM_CH+1 | Per-status-bit block for the general interrupt |
| smi_en | input | 1 | Enables the system-management interrupt output |
| irq_pol | input | 1 | Interrupt polarity: 1 active high |
| rd_clr | input | NREG | One-cycle read strobe per status byte; clears that byte |
| case_in | input | 1 | Chassis-intrusion line, asynchronous |
| case_clr_req | input | 1 | Request to start a clear pulse on the intrusion line |
| tick | input | 1 | One-cycle pulse from the slow timebase |
| status | output | NUM_CH+1 | Sticky status bits, case-open bit at index NUM_CH |
| smi_n | output | 1 | System-management interrupt, active low, meant for open drain |
| irq | output | 1 | General interrupt at the selected polarity |
| case_drive | output | 1 | 1 pulls the intrusion line low |

## Verification
The bench sweeps every combination of reading and limits on one narrow channel in both modes. In hysteresis mode it keeps a running model of the alarm, so that a design which released on a strict less-than, or which forgot its state between the limits, would leave a status bit wrong. Reading clear is applied on the same edge as a live alarm, so a design where the clear beats the set would drop the event. Mask, enable and polarity checks catch a design that gates the status bit itself rather than its route to an output. The clear-pulse checks bound the pulse length in ticks and retrigger the request mid-pulse, to catch a counter that restarts or ends one tick early.

// File: rtl/lw_pkg.sv
package lw_pkg;

  typedef enum logic {
    MODE_HYST   = 1'b0,
    MODE_WINDOW = 1'b1
  } cmp_mode_e;

  // number of status bytes needed for a given status width
  function automatic int bytes_for(input int bits);
    return (bits + 7) / 8;
  endfunction

endpackage

// File: rtl/lw_chan_cmp.sv
module lw_chan_cmp
  import lw_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          mode_win,
  input  logic [DW-1:0] val,
  input  logic [DW-1:0] hi,
  input  logic [DW-1:0] lo,
  output logic          alarm
);

  logic above_hi, below_lo, at_or_below_lo;
  cmp_mode_e mode;

  always_comb begin
    mode           = cmp_mode_e'(mode_win);
    above_hi       = val > hi;
    below_lo       = val < lo;
    at_or_below_lo = val <= lo;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm <= 1'b0;
    end else if (run) begin
      if (mode == MODE_WINDOW) begin
        alarm <= above_hi | below_lo;
      end else if (above_hi) begin
        alarm <= 1'b1;
      end else if (at_or_below_lo) begin
        alarm <= 1'b0;
      end
    end
  end

  // R5: a stopped comparator keeps its state
  a_r5_frozen: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(alarm));

  // R3: hysteresis holds an alarm while the reading stays above release
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (run && !mode_win && alarm && (val > lo)) |=> alarm);

  // R2: window mode never alarms on an in-range reading
  a_r2_in_range: assert property (@(posedge clk) disable iff (rst)
    (run && mode_win && (val <= hi) && (val >= lo)) |=> !alarm);

endmodule

// File: rtl/lw_status.sv
module lw_status #(
  parameter int STAT_W = 16,
  parameter int NREG   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] set_vec,
  input  logic [NREG-1:0]   rd_clr,
  output logic [STAT_W-1:0] status
);

  logic [STAT_W-1:0] clr_full;

  for (genvar gi = 0; gi < STAT_W; gi++) begin : g_clr
    assign clr_full[gi] = rd_clr[gi / 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
    end else begin
      status <= (status & ~clr_full) | set_vec;
    end
  end

  // R4: bits not cleared stay set
  a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status & $past(status & ~clr_full)) == $past(status & ~clr_full)));

  // R4: a set in the same cycle as a clear survives
  a_r4_set_wins: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status & $past(set_vec)) == $past(set_vec)));

  // R4: a bit only rises when its source asked for it
  a_r4_no_spurious: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status & ~$past(status) & ~$past(set_vec)) == '0));

endmodule

// File: rtl/lw_case_open.sv
module lw_case_open #(
  parameter int SYNC_STAGES = 2,
  parameter int PULSE_TICKS = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic case_in,
  input  logic clr_req,
  input  logic tick,
  output logic event_lvl,
  output logic drive
);

  localparam int CW = $clog2(PULSE_TICKS + 2);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   req_q;
  logic                   req_rise;
  logic [CW-1:0]          cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], case_in};
    end
  end

  assign event_lvl = sync_q[SYNC_STAGES-1];
  assign req_rise  = clr_req & ~req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      drive <= 1'b0;
      cnt   <= '0;
    end else begin
      req_q <= clr_req;
      if (!drive) begin
        if (req_rise) begin
          drive <= 1'b1;
          cnt   <= '0;
        end
      end else if (tick) begin
        if (cnt == CW'(PULSE_TICKS)) begin
          drive <= 1'b0;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R10: counter never runs past the programmed length
  a_r10_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(PULSE_TICKS));

  // R10: pulse only starts on a request edge
  a_r10_start: assert property (@(posedge clk) disable iff (rst)
    $rose(drive) |-> $past(req_rise));

  // R10: pulse only ends on a tick
  a_r10_end_on_tick: assert property (@(posedge clk) disable iff (rst)
    $fell(drive) |-> $past(tick));

endmodule

// File: rtl/lw_irq_out.sv
module lw_irq_out #(
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] status,
  input  logic [STAT_W-1:0] smi_mask,
  input  logic [STAT_W-1:0] irq_mask,
  input  logic              smi_en,
  input  logic              irq_pol,
  output logic              smi_n,
  output logic              irq
);

  logic smi_any, irq_any;

  always_comb begin
    smi_any = |(status & ~smi_mask);
    irq_any = |(status & ~irq_mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      smi_n <= 1'b1;
      irq   <= 1'b0;
    end else begin
      smi_n <= ~(smi_en & smi_any);
      irq   <= irq_pol ? irq_any : ~irq_any;
    end
  end

  // R7: disabled output stays released
  a_r7_smi_off: assert property (@(posedge clk) disable iff (rst)
    !smi_en |=> smi_n);

  // R7: output only asserts with some status bit set
  a_r7_smi_cause: assert property (@(posedge clk) disable iff (rst)
    !smi_n |-> $past(|status));

  // R8: all-masked status leaves interrupt at inactive level
  a_r8_idle: assert property (@(posedge clk) disable iff (rst)
    ((status & ~irq_mask) == '0) |=> (irq != $past(irq_pol)));

endmodule

// File: rtl/limit_watchdog.sv
module limit_watchdog
  import lw_pkg::*;
#(
  parameter  int NUM_CH      = 15,
  parameter  int DW          = 8,
  parameter  int SYNC_STAGES = 2,
  parameter  int PULSE_TICKS = 20,
  localparam int STAT_W      = NUM_CH + 1,
  localparam int NREG        = bytes_for(NUM_CH + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  logic [NUM_CH-1:0]    mode_win,
  input  logic [NUM_CH*DW-1:0] mon_val,
  input  logic [NUM_CH*DW-1:0] lim_hi,
  input  logic [NUM_CH*DW-1:0] lim_lo,
  input  logic [STAT_W-1:0]    smi_mask,
  input  logic [STAT_W-1:0]    irq_mask,
  input  logic                 smi_en,
  input  logic                 irq_pol,
  input  logic [NREG-1:0]      rd_clr,
  input  logic                 case_in,
  input  logic                 case_clr_req,
  input  logic                 tick,
  output logic [STAT_W-1:0]    status,
  output logic                 smi_n,
  output logic                 irq,
  output logic                 case_drive
);

  logic [NUM_CH-1:0] alarm;
  logic [STAT_W-1:0] set_vec;
  logic              case_evt;

  for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_ch
    lw_chan_cmp #(.DW(DW)) i_cmp (
      .clk      (clk),
      .rst      (rst),
      .run      (run),
      .mode_win (mode_win[gc]),
      .val      (mon_val[gc*DW +: DW]),
      .hi       (lim_hi[gc*DW +: DW]),
      .lo       (lim_lo[gc*DW +: DW]),
      .alarm    (alarm[gc])
    );
  end

  assign set_vec = {case_evt, alarm & {NUM_CH{run}}};

  lw_case_open #(
    .SYNC_STAGES (SYNC_STAGES),
    .PULSE_TICKS (PULSE_TICKS)
  ) i_case (
    .clk       (clk),
    .rst       (rst),
    .case_in   (case_in),
    .clr_req   (case_clr_req),
    .tick      (tick),
    .event_lvl (case_evt),
    .drive     (case_drive)
  );

  lw_status #(.STAT_W(STAT_W), .NREG(NREG)) i_status (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .rd_clr  (rd_clr),
    .status  (status)
  );

  lw_irq_out #(.STAT_W(STAT_W)) i_out (
    .clk      (clk),
    .rst      (rst),
    .status   (status),
    .smi_mask (smi_mask),
    .irq_mask (irq_mask),
    .smi_en   (smi_en),
    .irq_pol  (irq_pol),
    .smi_n    (smi_n),
    .irq      (irq)
  );

  // R5: no channel status appears while stopped, unless already set
  a_r5_no_set_stopped: assert property (@(posedge clk) disable iff (rst)
    !run |=> ((status[NUM_CH-1:0] & ~$past(status[NUM_CH-1:0])) == '0));

endmodule

// File: tb/test_limit_watchdog.sv
module test_limit_watchdog;

  localparam int NUM_CH = 4;
  localparam int DW     = 4;
  localparam int PT     = 3;
  localparam int TPER   = 4;
  localparam int SW     = NUM_CH + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b0;
  logic [NUM_CH-1:0] mode_win = '1;
  logic [NUM_CH*DW-1:0] mon_val = '0;
  logic [NUM_CH*DW-1:0] lim_hi = '1;
  logic [NUM_CH*DW-1:0] lim_lo = '0;
  logic [SW-1:0] smi_mask = '0;
  logic [SW-1:0] irq_mask = '0;
  logic smi_en = 1'b0;
  logic irq_pol = 1'b1;
  logic [0:0] rd_clr = '0;
  logic case_in = 1'b0;
  logic case_clr_req = 1'b0;
  logic tick = 1'b0;
  logic [SW-1:0] status;
  logic smi_n, irq, case_drive;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int tcnt = 0;

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tcnt <= (tcnt == TPER - 1) ? 0 : tcnt + 1;
    tick <= (tcnt == TPER - 1);
  end

  limit_watchdog #(
    .NUM_CH(NUM_CH), .DW(DW), .SYNC_STAGES(2), .PULSE_TICKS(PT)
  ) i_limit_watchdog (
    .clk(clk), .rst(rst), .run(run), .mode_win(mode_win),
    .mon_val(mon_val), .lim_hi(lim_hi), .lim_lo(lim_lo),
    .smi_mask(smi_mask), .irq_mask(irq_mask), .smi_en(smi_en),
    .irq_pol(irq_pol), .rd_clr(rd_clr), .case_in(case_in),
    .case_clr_req(case_clr_req), .tick(tick), .status(status),
    .smi_n(smi_n), .irq(irq), .case_drive(case_drive)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clk_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    rd_clr = 1'b1;
    clk_n(1);
    rd_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit model;
    int hi_cnt;
    clk_n(3);
    // R1: reset state
    chk(status == '0, "R1 status", int'(status), 0);
    chk(smi_n == 1'b1, "R1 smi_n", int'(smi_n), 1);
    chk(case_drive == 1'b0, "R1 drive", int'(case_drive), 0);
    rst = 1'b0;
    clk_n(1);
    chk(irq == 1'b0, "R1 irq idle", int'(irq), 0);

    // R2: window sweep on channel 0, R11 two-edge latency with clear
    run = 1'b1;
    mode_win = '1;
    for (int h = 0; h < 16; h++) begin
      for (int l = 0; l < 16; l++) begin
        for (int v = 0; v < 16; v++) begin
          lim_hi[3:0] = 4'(h);
          lim_lo[3:0] = 4'(l);
          mon_val[3:0] = 4'(v);
          clk_n(1);
          rd_clr = 1'b1;
          clk_n(1);
          rd_clr = 1'b0;
          model = (v > h) || (v < l);
          chk(status[3:0] == {3'b000, model}, "R2 R4 R11 window",
              int'(status[3:0]), int'(model));
        end
      end
    end

    // R3: hysteresis sweep with running model
    mode_win[0] = 1'b0;
    clk_n(1);
    model = 1'b0;
    mon_val[3:0] = 4'd0;
    lim_lo[3:0] = 4'd0;
    lim_hi[3:0] = 4'd15;
    clk_n(2);
    for (int h = 0; h < 16; h++) begin
      for (int l = 0; l < 16; l++) begin
        for (int v = 0; v < 16; v++) begin
          lim_hi[3:0] = 4'(h);
          lim_lo[3:0] = 4'(l);
          mon_val[3:0] = 4'(v);
          if (v > h) model = 1'b1;
          else if (v <= l) model = 1'b0;
          clk_n(1);
          rd_clr = 1'b1;
          clk_n(1);
          rd_clr = 1'b0;
          chk(status[0] == model, "R3 hysteresis", int'(status[0]), int'(model));
        end
      end
    end

    // R5: stopped comparators set nothing and hold state
    mode_win[0] = 1'b1;
    lim_hi[3:0] = 4'd8;
    lim_lo[3:0] = 4'd2;
    mon_val[3:0] = 4'd5;
    clk_n(2);
    clear_all();
    run = 1'b0;
    mon_val[3:0] = 4'd12;
    clk_n(3);
    clear_all();
    chk(status == '0, "R5 stopped", int'(status), 0);
    run = 1'b1;
    clk_n(2);
    chk(status[0] == 1'b1, "R5 resumed", int'(status[0]), 1);
    mon_val[3:0] = 4'd5;
    clk_n(2);
    clear_all();

    // R4: sticky without clear
    mon_val[3:0] = 4'd15;
    clk_n(2);
    mon_val[3:0] = 4'd5;
    clk_n(4);
    chk(status[0] == 1'b1, "R4 sticky", int'(status[0]), 1);
    clear_all();
    chk(status[0] == 1'b0, "R4 cleared", int'(status[0]), 0);

    // R6: case-open latched even when stopped
    run = 1'b0;
    case_in = 1'b1;
    clk_n(3);
    chk(status[4] == 1'b1, "R6 case bit", int'(status[4]), 1);
    case_in = 1'b0;
    clk_n(3);
    clear_all();
    chk(status[4] == 1'b0, "R6 case cleared", int'(status[4]), 0);
    case_in = 1'b1;
    clk_n(3);
    case_in = 1'b0;
    clk_n(3);

    // R7: disabled, then enabled, then masked
    smi_en = 1'b0;
    clk_n(2);
    chk(smi_n == 1'b1, "R7 smi disabled", int'(smi_n), 1);
    smi_en = 1'b1;
    clk_n(2);
    chk(smi_n == 1'b0, "R7 smi asserted", int'(smi_n), 0);
    smi_mask[4] = 1'b1;
    clk_n(2);
    chk(smi_n == 1'b1, "R7 smi masked", int'(smi_n), 1);
    // R9: masked bit remains visible
    chk(status[4] == 1'b1, "R9 masked still set", int'(status[4]), 1);

    // R8: polarity both ways and mask
    irq_pol = 1'b1;
    clk_n(2);
    chk(irq == 1'b1, "R8 irq high", int'(irq), 1);
    irq_pol = 1'b0;
    clk_n(2);
    chk(irq == 1'b0, "R8 irq low", int'(irq), 0);
    irq_mask[4] = 1'b1;
    clk_n(2);
    chk(irq == 1'b1, "R8 irq masked idle", int'(irq), 1);
    irq_mask = '0;
    smi_mask = '0;
    clear_all();
    clk_n(2);
    chk(irq == 1'b1 && smi_n == 1'b1, "R8 R7 idle after clear",
        int'({irq, smi_n}), 3);

    // R10: pulse length, retrigger ignored
    case_clr_req = 1'b1;
    clk_n(1);
    chk(case_drive == 1'b1, "R10 drive starts", int'(case_drive), 1);
    hi_cnt = 0;
    while (case_drive && hi_cnt < 100) begin
      if (hi_cnt == 5) case_clr_req = 1'b0;
      if (hi_cnt == 7) case_clr_req = 1'b1;
      clk_n(1);
      hi_cnt++;
    end
    chk(hi_cnt >= PT * TPER && hi_cnt <= (PT + 1) * TPER + 1,
        "R10 pulse length", hi_cnt, (PT + 1) * TPER);
    clk_n(20);
    chk(case_drive == 1'b0, "R10 held request no restart", int'(case_drive), 0);
    case_clr_req = 1'b0;
    clk_n(2);
    case_clr_req = 1'b1;
    clk_n(1);
    chk(case_drive == 1'b1, "R10 new edge restarts", int'(case_drive), 1);
    case_clr_req = 1'b0;
    clk_n(30);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule